// File: doc/BRIEF.md
# Block-Rollback FIFO

A synchronous single-clock FIFO, 512 words of 18 bits by default. The producer can record a mark at the start of a block it is about to write. If the block turns out to be bad, the producer pulses rollback. The write pointer then returns to the mark, the partial block is discarded, and later writes overwrite it from its first slot.

A live `protect_i` input changes only the empty flag. When it is set, the reader sees empty once its pointer reaches the mark, so nothing written after the mark is visible until the producer loads the mark again. This gives commit-style publishing of whole blocks. The full flag always compares the write pointer against the read pointer, whatever the setting of `protect_i`. Read data comes from a register and is valid the cycle after a read is accepted.

Top module: `mark_fifo`

## Requirements
- R1: After reset, `empty_o`=1, `full_o`=0 and `rd_data_o`=0. The write, read and mark pointers are all zero.
- R2: Words are read in the order they were written. `rd_data_o` shows the word one clock edge after the edge that accepts the read (`rd_en_i`=1 while `empty_o`=0).
- R3: `full_o` rises after DEPTH more accepted writes than reads. A write attempted while full stores nothing and moves no pointer.
- R4: A read attempted while `empty_o`=1 moves no pointer. `rd_data_o` holds its last value on every cycle that has no accepted read.
- R5: `mark_i` copies the write pointer into the mark. If a write is accepted in the same cycle, the mark takes the pointer value from before that write.
- R6: `rollback_i` loads the write pointer with the mark. A write requested in the same cycle is dropped.
- R7: If `mark_i` and `rollback_i` are high together, rollback takes effect and the mark keeps its old value.
- R8: With `protect_i`=1, `empty_o` is 1 exactly when the read pointer equals the mark. Words written after the mark cannot be read until the mark is loaded again.
- R9: With `protect_i`=0, `empty_o` is 1 exactly when the read pointer equals the write pointer, wherever the mark is.
- R10: `full_o` is 1 exactly when the write pointer equals the read pointer plus DEPTH (wrap bit differs, address bits equal). This holds for both values of `protect_i`.
- R11: When neither flag blocks them, a read and a write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| protect_i | input | 1 | 1: empty is measured against the mark |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Write data |
| mark_i | input | 1 | Copy the write pointer into the mark |
| rollback_i | input | 1 | Return the write pointer to the mark |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Registered read data |
| full_o | output | 1 | FIFO holds DEPTH words |
| empty_o | output | 1 | Nothing readable |

## Verification
The assertions check on every cycle the pointer relations that can be seen at the pointers themselves:
- occupancy never exceeds DEPTH;
- no pointer moves when a full or empty flag blocks it;
- rollback lands on the mark and leaves the mark unchanged;
- a mark load captures the pre-write pointer;
- read data holds when there is no read.

Only the bench scenarios can show the end-to-end data effects: which words survive a rollback, words hidden under protection and then published by a later mark, a full FIFO draining in order in both modes, and the order of the returned data.

// File: rtl/mark_fifo_pkg.sv
package mark_fifo_pkg;
  typedef enum logic [1:0] {
    WP_HOLD = 2'd0,
    WP_ADV  = 2'd1,
    WP_ROLL = 2'd2
  } wp_op_e;
endpackage

// File: rtl/mark_fifo_ctrl.sv
module mark_fifo_ctrl
  import mark_fifo_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          protect_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic          mark_i,
  input  logic          rollback_i,
  output logic          wr_fire_o,
  output logic          rd_fire_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;

  logic [PW-1:0] wr_q, rd_q, mk_q;
  wp_op_e        wp_op;

  assign full_o    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign empty_o   = protect_i ? (rd_q == mk_q) : (rd_q == wr_q);
  assign wr_fire_o = wr_en_i && !full_o && !rollback_i;
  assign rd_fire_o = rd_en_i && !empty_o;
  assign wr_addr_o = wr_q[AW-1:0];
  assign rd_addr_o = rd_q[AW-1:0];

  always_comb begin
    if (rollback_i)     wp_op = WP_ROLL;
    else if (wr_fire_o) wp_op = WP_ADV;
    else                wp_op = WP_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
      mk_q <= '0;
    end else begin
      case (wp_op)
        WP_ADV:  wr_q <= wr_q + PW'(1);
        WP_ROLL: wr_q <= mk_q;
        default: wr_q <= wr_q;
      endcase
      if (rd_fire_o) rd_q <= rd_q + PW'(1);
      // rollback outranks a coincident mark load
      if (mark_i && !rollback_i) mk_q <= wr_q;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PW'(wr_q - rd_q) <= DEPTH_P);
  a_r3_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !rollback_i |=> wr_q == $past(wr_q));
  a_r4_empty_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |=> rd_q == $past(rd_q));
  a_r5_mark_pre_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_i && !rollback_i |=> mk_q == $past(wr_q));
  a_r6_rollback_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_i |=> wr_q == $past(mk_q));
  a_r7_mark_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_i |=> $stable(mk_q));
  a_r8_no_pass_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protect_i && (rd_q == mk_q) |=> rd_q == $past(rd_q));
endmodule

// File: rtl/mark_fifo_mem.sv
module mark_fifo_mem #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 512,
  parameter int AW     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end

  a_r4_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/mark_fifo.sv
module mark_fifo #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              protect_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              mark_i,
  input  logic              rollback_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_fire, rd_fire;
  logic [AW-1:0] wr_addr, rd_addr;

  mark_fifo_ctrl #(.AW(AW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .protect_i  (protect_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .mark_i     (mark_i),
    .rollback_i (rollback_i),
    .wr_fire_o  (wr_fire),
    .rd_fire_o  (rd_fire),
    .wr_addr_o  (wr_addr),
    .rd_addr_o  (rd_addr),
    .full_o     (full_o),
    .empty_o    (empty_o)
  );

  mark_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_fire),
    .waddr_i (wr_addr),
    .wdata_i (wr_data_i),
    .re_i    (rd_fire),
    .raddr_i (rd_addr),
    .rdata_o (rd_data_o)
  );
endmodule

// File: tb/sim_mark_fifo.sv
`timescale 1ns/1ps
module sim_mark_fifo;
  localparam int DW = 18;
  localparam int DEPTH = 512;

  logic clk = 0;
  logic rst_ni = 0;
  logic protect_i = 0, wr_en_i = 0, mark_i = 0, rollback_i = 0, rd_en_i = 0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic full_o, empty_o;

  always #4 clk = ~clk;

  mark_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .protect_i(protect_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .mark_i(mark_i), .rollback_i(rollback_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .full_o(full_o), .empty_o(empty_o)
  );

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, rd_cnt = 0, mark_cnt = 0;
  logic [DW-1:0] mdl [int];
  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] last_rd = '0;
  bit rd_fire = 0;
  string cur_tag = "R2";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one cycle, inputs applied just after a falling edge
  task automatic step(input bit p, input bit w, input logic [DW-1:0] d,
                      input bit r, input bit m, input bit b, input string tag);
    bit xf, xe, wa, ra;
    protect_i = p;
    #1;
    xf = (wr_cnt - rd_cnt) == DEPTH;
    xe = p ? (rd_cnt == mark_cnt) : (rd_cnt == wr_cnt);
    chk(full_o == xf, {tag, " full"}, int'(full_o), int'(xf));
    chk(empty_o == xe, {tag, " empty"}, int'(empty_o), int'(xe));
    wa = w && !xf && !b;
    ra = r && !xe;
    wr_en_i = w; wr_data_i = d; rd_en_i = r; mark_i = m; rollback_i = b;
    cur_tag = tag;
    if (ra) begin
      exp_q.push_back(mdl[rd_cnt]);
      rd_cnt++;
    end
    rd_fire = ra;
    if (b) wr_cnt = mark_cnt;
    else begin
      if (m) mark_cnt = wr_cnt;
      if (wa) begin
        mdl[wr_cnt] = d;
        wr_cnt++;
      end
    end
    @(negedge clk);
  endtask

  // monitor: compares read data after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_ni) begin
      if (rd_fire) begin
        last_rd = exp_q.pop_front();
        chk(rd_data_o == last_rd, {"R2 data ", cur_tag}, int'(rd_data_o), int'(last_rd));
      end else begin
        chk(rd_data_o == last_rd, {"R4 hold ", cur_tag}, int'(rd_data_o), int'(last_rd));
      end
    end
  end

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 37 + 5) ^ 18'h2a5a5;
  endfunction

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(empty_o == 1'b1, "R1 empty", int'(empty_o), 1);
    chk(full_o == 1'b0, "R1 full", int'(full_o), 0);
    chk(rd_data_o == '0, "R1 data", int'(rd_data_o), 0);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R4: reads on an empty FIFO
    for (int i = 0; i < 3; i++) step(0, 0, '0, 1, 0, 0, "R4");
    // R2 / R11: plain traffic, then simultaneous read and write
    for (int i = 0; i < 5; i++) step(0, 1, pat(i), 0, 0, 0, "R2");
    for (int i = 5; i < 12; i++) step(0, 1, pat(i), 1, 0, 0, "R11");
    for (int i = 0; i < 6; i++) step(0, 0, '0, 1, 0, 0, "R2");
    step(0, 0, '0, 1, 0, 0, "R4");

    // R3 / R10: fill unprotected, overfill, drain
    for (int i = 0; i < DEPTH; i++) step(0, 1, pat(100 + i), 0, 0, 0, "R3");
    step(0, 1, 18'h3ffff, 0, 0, 0, "R10");
    step(0, 1, 18'h12345, 0, 0, 0, "R3");
    for (int i = 0; i < DEPTH; i++) step(0, 0, '0, 1, 0, 0, "R3");
    step(0, 0, '0, 1, 0, 0, "R4");

    // R5 / R6: mark with coincident write, rollback with dropped write
    step(0, 1, 18'h0000a, 0, 0, 0, "R5");
    step(0, 1, 18'h0000b, 0, 1, 0, "R5");
    step(0, 1, 18'h0000c, 0, 0, 0, "R6");
    step(0, 1, 18'h0000d, 0, 0, 1, "R6");
    step(0, 1, 18'h0000e, 0, 0, 0, "R6");
    for (int i = 0; i < 3; i++) step(0, 0, '0, 1, 0, 0, "R6");

    // R7: mark and rollback together keep the old mark
    step(0, 0, '0, 0, 1, 0, "R7");
    step(0, 1, 18'h00f0f, 0, 0, 0, "R7");
    step(0, 1, 18'h00f1f, 0, 0, 0, "R7");
    step(0, 0, '0, 0, 1, 1, "R7");
    step(0, 1, 18'h00abc, 0, 0, 0, "R7");
    step(0, 0, '0, 0, 0, 1, "R7");
    step(0, 1, 18'h00def, 0, 0, 0, "R7");
    for (int i = 0; i < 2; i++) step(0, 0, '0, 1, 0, 0, "R7");

    // R8: protected block hidden until the mark moves
    step(0, 0, '0, 0, 1, 0, "R8");
    for (int i = 0; i < 3; i++) step(1, 1, pat(900 + i), 1, 0, 0, "R8");
    step(1, 0, '0, 1, 0, 0, "R8");
    step(1, 0, '0, 0, 1, 0, "R8");
    for (int i = 0; i < 4; i++) step(1, 0, '0, 1, 0, 0, "R8");

    // R9: unprotected ignores a stale mark
    for (int i = 0; i < 2; i++) step(0, 1, pat(950 + i), 0, 0, 0, "R9");
    step(1, 0, '0, 1, 0, 0, "R9");
    for (int i = 0; i < 3; i++) step(0, 0, '0, 1, 0, 0, "R9");

    // R10: full under protection, then publish and drain
    step(0, 0, '0, 0, 1, 0, "R10");
    for (int i = 0; i < DEPTH; i++) step(1, 1, pat(2000 + i), 0, 0, 0, "R10");
    step(1, 1, 18'h1ffff, 1, 0, 0, "R10");
    step(1, 0, '0, 0, 1, 0, "R10");
    for (int i = 0; i < DEPTH; i++) step(1, 0, '0, 1, 0, 0, "R10");
    step(1, 0, '0, 1, 0, 0, "R8");
    step(0, 0, '0, 0, 0, 0, "R4");
    step(0, 0, '0, 0, 0, 0, "R4");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule